// File: doc/BRIEF.md
# Bit-Sliced Arithmetic Logic Unit with Signed Compare

This block is a small combinational arithmetic logic unit. It takes two operands and a 3-bit function code. It returns a result word together with a zero flag and a signed overflow flag. The default operand width is 4 bits. The datapath is written entirely with primitive gates (and, or, not, xor) and structural instances.

The datapath is split into bit slices. A common slice serves every position except the top one. That slice holds an operand inverter, a full adder and a four-way selector. The top position uses its own slice type, which adds two outputs: the raw adder overflow and the signed less-than bit. The less-than bit is routed back into the lowest result position. The slices are joined by a ripple carry.

The function code is split into two fields. Bit 2 inverts B and also supplies the carry into slice 0. Bits 1:0 pick which slice output appears at the result. As a consequence, subtraction is add with invert, and set-less-than is subtraction with the compare output selected.

Top module: `bitslice_alu`

## Requirements
- R1: Function code field meaning: op[2]=1 inverts every bit of B and forces the carry into bit 0 to 1. op[1:0] selects the per-bit output: 00 AND, 01 OR, 10 adder sum, 11 compare bit. The named operations are 000 AND, 001 OR, 010 ADD, 110 SUB, 111 SLT.
- R2: With op=000, result equals A AND B.
- R3: With op=001, result equals A OR B.
- R4: With op=010, result equals (A+B) modulo 16.
- R5: With op=110, result equals (A−B) modulo 16.
- R6: With op=111, result is 0001 when A is less than B as signed two's-complement values and 0000 otherwise. This holds even when A−B overflows, for example A=1000, B=0001 gives 0001.
- R7: zero is 1 exactly when every result bit is 0, for every function code.
- R8: For op[1:0]=10 (ADD and SUB), overflow is 1 exactly when the signed sum A+B (or difference A−B) lies outside −8..7. For example, 0111+0001 and 1000−0001 both give overflow=1.
- R9: overflow is 0 whenever op[1:0] is not 10. This covers AND, OR and SLT.
- R10: The remaining codes follow the same field rules. 100 gives A AND NOT B, 101 gives A OR NOT B, and 011 returns the compare bit of A+B in bit 0.
- R11: The block holds no state. All outputs follow the present inputs within the same cycle, and all-zero inputs give result 0000 with zero=1 and overflow=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 3 | Function code |
| result_o | output | WIDTH | Result word |
| zero_o | output | 1 | High when result is all zeros |
| overflow_o | output | 1 | Signed overflow for ADD and SUB |

## Verification
The hardest case to reach is a signed compare whose internal subtraction overflows. In that case the sign bit alone gives the wrong answer, and only the XOR with the overflow term fixes it. That case needs operands of opposite sign near the ends of the range. The stimulus therefore sweeps all 256 operand pairs under all eight function codes, which reaches every such pair. Named cases at the range edges are added on top of the sweep.

// File: rtl/alu_pkg.sv
package alu_pkg;
   // Selector field op[1:0]: which per-bit value reaches the result
   typedef enum logic [1:0] {
      FN_AND  = 2'b00,
      FN_OR   = 2'b01,
      FN_SUM  = 2'b10,
      FN_LESS = 2'b11
   } fn_e;

   localparam logic [2:0] OP_AND = 3'b000;
   localparam logic [2:0] OP_OR  = 3'b001;
   localparam logic [2:0] OP_ADD = 3'b010;
   localparam logic [2:0] OP_SUB = 3'b110;
   localparam logic [2:0] OP_SLT = 3'b111;
endpackage

// File: rtl/alu_mux4.sv
module alu_mux4 (
   input  logic       d0,
   input  logic       d1,
   input  logic       d2,
   input  logic       d3,
   input  logic [1:0] sel,
   output logic       y
);
   logic s0n, s1n, t0, t1, t2, t3;

   not n_s0 (s0n, sel[0]);
   not n_s1 (s1n, sel[1]);
   and g_t0 (t0, d0, s1n, s0n);
   and g_t1 (t1, d1, s1n, sel[0]);
   and g_t2 (t2, d2, sel[1], s0n);
   and g_t3 (t3, d3, sel[1], sel[0]);
   or  g_y  (y, t0, t1, t2, t3);

   always_comb begin
      a_r1_mux_pick: assert (y == (sel == 2'b00 ? d0 : sel == 2'b01 ? d1 :
                                   sel == 2'b10 ? d2 : d3));
   end
endmodule

// File: rtl/alu_full_adder.sv
module alu_full_adder (
   input  logic a,
   input  logic b,
   input  logic ci,
   output logic s,
   output logic co
);
   logic p, g, pc;

   xor g_p  (p, a, b);
   xor g_s  (s, p, ci);
   and g_g  (g, a, b);
   and g_pc (pc, p, ci);
   or  g_co (co, g, pc);

   always_comb begin
      a_r4_adder_sum: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {1'b0, ci}));
   end
endmodule

// File: rtl/alu_slice.sv
module alu_slice (
   input  logic       a,
   input  logic       b,
   input  logic       less,
   input  logic       binv,
   input  logic       cin,
   input  logic [1:0] fn,
   output logic       res,
   output logic       cout
);
   logic bx, and_v, or_v, sum_v;

   xor g_bx  (bx, b, binv);
   and g_and (and_v, a, bx);
   or  g_or  (or_v, a, bx);

   alu_full_adder u_fa (.a(a), .b(bx), .ci(cin), .s(sum_v), .co(cout));
   alu_mux4 u_mux (.d0(and_v), .d1(or_v), .d2(sum_v), .d3(less), .sel(fn), .y(res));

   always_comb begin
      if (fn == alu_pkg::FN_AND)
         a_r2_slice_and: assert (res == (a & (b ^ binv)));
      if (fn == alu_pkg::FN_OR)
         a_r3_slice_or: assert (res == (a | (b ^ binv)));
   end
endmodule

// File: rtl/alu_slice_msb.sv
module alu_slice_msb (
   input  logic       a,
   input  logic       b,
   input  logic       less,
   input  logic       binv,
   input  logic       cin,
   input  logic [1:0] fn,
   output logic       res,
   output logic       set,
   output logic       ovf_raw
);
   logic bx, and_v, or_v, sum_v, cout;

   xor g_bx  (bx, b, binv);
   and g_and (and_v, a, bx);
   or  g_or  (or_v, a, bx);

   alu_full_adder u_fa (.a(a), .b(bx), .ci(cin), .s(sum_v), .co(cout));

   // signed overflow: carry into top differs from carry out of top
   xor g_ov  (ovf_raw, cin, cout);
   // corrected sign of the difference
   xor g_set (set, sum_v, ovf_raw);

   alu_mux4 u_mux (.d0(and_v), .d1(or_v), .d2(sum_v), .d3(less), .sel(fn), .y(res));

   always_comb begin
      a_r8_msb_overflow: assert (ovf_raw == ((a == bx) && (sum_v != a)));
      a_r6_msb_set: assert (set == (ovf_raw ? a : sum_v));
   end
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [2:0]       op_i,
   output logic [WIDTH-1:0] result_o,
   output logic             zero_o,
   output logic             overflow_o
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("bitslice_alu: WIDTH must be at least 2");
      end
   endgenerate

   logic       binv;
   logic [1:0] fn;
   logic       set_bit;
   logic       ovf_raw;
   logic       msb_cin;

   assign binv = op_i[2];
   assign fn   = op_i[1:0];

   generate
      for (genvar i = 0; i < MSB; i++) begin : g_lo
         logic ci, co, lss;
         if (i == 0) begin : g_first
            assign ci  = binv;
            assign lss = set_bit;
         end else begin : g_next
            assign ci  = g_lo[i-1].co;
            assign lss = 1'b0;
         end
         alu_slice u_slice (
            .a(a_i[i]), .b(b_i[i]), .less(lss), .binv(binv),
            .cin(ci), .fn(fn), .res(result_o[i]), .cout(co)
         );
      end
   endgenerate

   assign msb_cin = g_lo[MSB-1].co;

   alu_slice_msb u_msb (
      .a(a_i[MSB]), .b(b_i[MSB]), .less(1'b0), .binv(binv),
      .cin(msb_cin), .fn(fn), .res(result_o[MSB]),
      .set(set_bit), .ovf_raw(ovf_raw)
   );

   // overflow reported only when the sum is selected (ADD / SUB)
   logic fn0n;
   not g_fn0n (fn0n, fn[0]);
   and g_ovf  (overflow_o, ovf_raw, fn[1], fn0n);

   // zero flag: OR chain then invert
   generate
      for (genvar k = 0; k < WIDTH; k++) begin : g_zor
         logic any;
         if (k == 0) begin : g_z0
            assign any = result_o[0];
         end else begin : g_zk
            or g_o (any, g_zor[k-1].any, result_o[k]);
         end
      end
   endgenerate
   not g_zero (zero_o, g_zor[MSB].any);

   always_comb begin
      a_r7_zero_flag: assert (zero_o == (result_o == '0));
      if (fn != alu_pkg::FN_SUM)
         a_r9_no_overflow: assert (!overflow_o);
      if (fn == alu_pkg::FN_LESS)
         a_r6_upper_clear: assert (result_o[MSB:1] == '0);
   end
endmodule

// File: tb/tb_bitslice_alu.sv
module tb_bitslice_alu;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] a, b, res;
   logic [2:0] op;
   logic       zero, ovf;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bitslice_alu #(.WIDTH(4)) dut (
      .a_i(a), .b_i(b), .op_i(op),
      .result_o(res), .zero_o(zero), .overflow_o(ovf)
   );

   function automatic int sgn(input logic [3:0] v);
      return v[3] ? int'(v) - 16 : int'(v);
   endfunction

   task automatic model(input logic [3:0] ea, input logic [3:0] eb, input logic [2:0] eo,
                        output logic [3:0] er, output logic ez, output logic ev);
      logic [3:0] bb;
      int cin, full, uns;
      logic [3:0] s4;
      logic orange, lt;
      bb = eo[2] ? ~eb : eb;
      cin = eo[2] ? 1 : 0;
      uns = int'(ea) + int'(bb) + cin;
      s4 = uns[3:0];
      full = sgn(ea) + sgn(bb) + cin;
      orange = (full > 7) || (full < -8);
      lt = s4[3] ^ orange;
      case (eo[1:0])
         2'b00:   er = ea & bb;
         2'b01:   er = ea | bb;
         2'b10:   er = s4;
         default: er = {3'b000, lt};
      endcase
      ev = (eo[1:0] == 2'b10) ? orange : 1'b0;
      ez = (er == 4'b0000);
   endtask

   function automatic string tag(input logic [2:0] o);
      case (o)
         3'b000: return "R2";
         3'b001: return "R3";
         3'b010: return "R4";
         3'b110: return "R5";
         3'b111: return "R6";
         default: return "R10";
      endcase
   endfunction

   task automatic apply(input logic [3:0] ta, input logic [3:0] tb_, input logic [2:0] to,
                        input string req);
      logic [3:0] er;
      logic ez, ev;
      @(posedge clk);
      #1;
      a = ta; b = tb_; op = to;
      @(negedge clk);
      model(ta, tb_, to, er, ez, ev);
      total++;
      if (res !== er) begin
         bad++;
         $display("FAIL %s result op=%b a=%b b=%b actual=%b expected=%b", req, to, ta, tb_, res, er);
      end
      total++;
      if (zero !== ez) begin
         bad++;
         $display("FAIL R7 zero op=%b a=%b b=%b actual=%b expected=%b", to, ta, tb_, zero, ez);
      end
      total++;
      if (ovf !== ev) begin
         bad++;
         $display("FAIL %s overflow op=%b a=%b b=%b actual=%b expected=%b",
                  (to[1:0] == 2'b10) ? "R8" : "R9", to, ta, tb_, ovf, ev);
      end
   endtask

   task automatic fixed(input logic [3:0] ta, input logic [3:0] tb_, input logic [2:0] to,
                        input logic [3:0] xr, input logic xv, input string req);
      @(posedge clk);
      #1;
      a = ta; b = tb_; op = to;
      @(negedge clk);
      total++;
      if (res !== xr || ovf !== xv) begin
         bad++;
         $display("FAIL %s fixed op=%b a=%b b=%b actual=%b/%b expected=%b/%b",
                  req, to, ta, tb_, res, ovf, xr, xv);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      a = '0; b = '0; op = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R11: idle inputs give the quiet state
      @(negedge clk);
      total++;
      if (res !== 4'b0000 || zero !== 1'b1 || ovf !== 1'b0) begin
         bad++;
         $display("FAIL R11 idle actual=%b/%b/%b expected=0000/1/0", res, zero, ovf);
      end
      // named edge cases: R8 overflow, R6 compare across overflow, R1 code fields
      fixed(4'b0111, 4'b0001, 3'b010, 4'b1000, 1'b1, "R8");
      fixed(4'b1000, 4'b0001, 3'b110, 4'b0111, 1'b1, "R8");
      fixed(4'b1000, 4'b0001, 3'b111, 4'b0001, 1'b0, "R6");
      fixed(4'b0111, 4'b1000, 3'b111, 4'b0000, 1'b0, "R6");
      fixed(4'b0011, 4'b0011, 3'b111, 4'b0000, 1'b0, "R6");
      fixed(4'b1100, 4'b1010, 3'b000, 4'b1000, 1'b0, "R2");
      fixed(4'b1100, 4'b1010, 3'b001, 4'b1110, 1'b0, "R3");
      fixed(4'b0101, 4'b0011, 3'b110, 4'b0010, 1'b0, "R5");
      fixed(4'b1100, 4'b1010, 3'b100, 4'b0100, 1'b0, "R1");
      fixed(4'b0111, 4'b0111, 3'b111, 4'b0000, 1'b0, "R9");
      // exhaustive sweep, every code (R10 covers the unnamed codes)
      for (int o = 0; o < 8; o++)
         for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
               apply(4'(i), 4'(j), 3'(o), tag(3'(o)));
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule